// File: doc/BRIEF.md
# Expansion Card Address Decoder

This block decodes bus addresses for a memory-mapped expansion card on a 16-bit address bus. An eight-bit control latch, loaded one bit at a time through a bit-addressed serial control port, decides whether the card responds at all. It also decides whether a second SRAM window is open, and whether the 256-byte page at 0x4000 shows the card's device registers or SRAM. A boot-time mapping switch sets which value of the mapping bit opens the register window, so the card can start with either view.

From the latch, the switch, a card-space qualifier and the bus address, the block produces registered selects: register window, SRAM, auxiliary RAM, clock register port, and two disk-controller register groups, each group split into a read port and a write port. The SRAM, auxiliary RAM, clock and four disk-port selects are mutually exclusive. The register-window select is a summary flag that covers the last six of these. The block also gives the clock register index, the auxiliary RAM index, and the latch bits that drive the write protect, interrupt enable, drive reset and SRAM paging controls. The SRAM page store and the attached devices live outside.

Top module: `xcard_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every latch bit is cleared and every select and index output is 0 after that edge, so the card starts disabled.
- R2: A control write (`ctl_we` high) stores `ctl_bit` into latch bit `ctl_addr[3:1]` only when `ctl_addr[15:8]` equals the `CARD_BASE` parameter (default 0x11). Bits `ctl_addr[7:4]` and `ctl_addr[0]` are ignored, and a write with any other upper byte leaves the latch unchanged.
- R3: Latch bits appear on outputs one cycle after the write: bit 0 on `card_en`, bits 3:2 on `page_ctl[1:0]`, bit 5 on `sram_wprot`, bit 6 on `irq_en`, bit 7 on `drive_rst`.
- R4: `sel_win` is high for addresses 0x4000-0x40FF only when latch bit 0 is 1 and latch bit 1 equals `map_sw`.
- R5: `sel_sram` is high for 0x4000-0x5FFF when latch bit 0 is 1 and the register window is not selected for that address.
- R6: `sel_sram` is high for 0x6000-0x7FFF whenever latch bit 4 is 1, whatever the value of latch bit 0.
- R7: Inside the register window, address bits [6:5] choose the device: 00 gives `sel_aux`, 01 gives `sel_rtc`, 10 gives disk group 1, 11 gives disk group 2. The pattern repeats every 0x80 bytes.
- R8: Within a disk group, address bit 4 = 0 raises the read select and address bit 4 = 1 raises the write select.
- R9: `rtc_index` equals address bits [4:1], so each clock register also answers on the odd address next to it.
- R10: `aux_index` equals address bit 7 followed by address bits [4:0], placing auxiliary byte 32 (the page register) at 0x4080.
- R11: When `space_ok` is low, all selects are low in the following cycle. In any cycle at most one of `sel_sram`, `sel_aux`, `sel_rtc` and the four disk selects is high, and `sel_win` and `sel_sram` are never high together.
- R12: Selects and indexes are registered: they reflect the address, qualifier and latch present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control-port write strobe |
| ctl_addr | input | 16 | Control-port address: base in [15:8], bit number in [3:1] |
| ctl_bit | input | 1 | Value written to the addressed latch bit |
| map_sw | input | 1 | Boot-time mapping switch level |
| space_ok | input | 1 | Card-space qualifier for the current bus cycle |
| bus_addr | input | 16 | Bus address to decode |
| sel_win | output | 1 | Register window selected |
| sel_sram | output | 1 | SRAM selected |
| sel_aux | output | 1 | Auxiliary RAM selected |
| sel_rtc | output | 1 | Clock register port selected |
| sel_ide1_rd | output | 1 | Disk group 1 read port |
| sel_ide1_wr | output | 1 | Disk group 1 write port |
| sel_ide2_rd | output | 1 | Disk group 2 read port |
| sel_ide2_wr | output | 1 | Disk group 2 write port |
| rtc_index | output | 4 | Clock register index |
| aux_index | output | 6 | Auxiliary RAM index |
| card_en | output | 1 | Card enable bit |
| page_ctl | output | 2 | Paging control bits for the external page store |
| sram_wprot | output | 1 | SRAM write protect |
| irq_en | output | 1 | Disk interrupt enable |
| drive_rst | output | 1 | Drive reset |

## Verification
The assertions assume that `ctl_addr` and `bus_addr` have known values after reset and that `map_sw` only moves while the card is disabled, so that a switch change never lands in the same cycle as a decode being checked. The stimulus drives every input on the falling edge. It changes `map_sw` only with latch bit 0 cleared. It mixes directed sweeps across every window boundary and the 0x80 mirror with a random phase of addresses between 0x3F00 and 0x80FF, including writes to the control port with a foreign base and with junk in the unused address bits.

// File: rtl/xcard_pkg.sv
package xcard_pkg;

  // Latch bit positions; the decoder and the paging logic outside depend on them.
  localparam int LB_ENABLE = 0;
  localparam int LB_MAPSEL = 1;
  localparam int LB_PAGE0  = 2;
  localparam int LB_PAGE1  = 3;
  localparam int LB_UPPER  = 4;
  localparam int LB_WPROT  = 5;
  localparam int LB_IRQ    = 6;
  localparam int LB_DRVRST = 7;

  localparam int NUM_IDE = 2;

  // Sub-region codes taken from address bits [6:5] inside the register window.
  typedef enum logic [1:0] {
    SUB_AUX  = 2'b00,
    SUB_RTC  = 2'b01,
    SUB_IDE1 = 2'b10,
    SUB_IDE2 = 2'b11
  } sub_e;

  typedef struct packed {
    logic                win;
    logic                sram;
    logic                aux;
    logic                rtc;
    logic [NUM_IDE-1:0]  ide_rd;
    logic [NUM_IDE-1:0]  ide_wr;
  } sel_t;

endpackage

// File: rtl/xcard_ctl_latch.sv
module xcard_ctl_latch #(
  parameter int          ADDR_W    = 16,
  parameter int          LATCH_W   = 8,
  parameter logic [7:0]  CARD_BASE = 8'h11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [ADDR_W-1:0]  ctl_addr,
  input  logic               ctl_bit,
  output logic [LATCH_W-1:0] latch_q
);
  localparam int IDX_W  = $clog2(LATCH_W);
  localparam int BASE_W = 8;

  logic             hit;
  logic [IDX_W-1:0] bit_sel;
  logic             unused_ctl_bits;

  assign hit     = ctl_we && (ctl_addr[ADDR_W-1 -: BASE_W] == CARD_BASE);
  assign bit_sel = ctl_addr[IDX_W:1];
  assign unused_ctl_bits = ^{ctl_addr[ADDR_W-BASE_W-1:IDX_W+1], ctl_addr[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (hit) begin
      latch_q[bit_sel] <= ctl_bit;
    end
  end

  // R2: a write aimed at another card leaves the latch alone
  assert_foreign_base_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_addr[ADDR_W-1 -: BASE_W] != CARD_BASE) |=> $stable(latch_q));

  // R2: an accepted write lands its data in the addressed bit
  assert_bit_store_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> (latch_q[$past(bit_sel)] == $past(ctl_bit)));

endmodule

// File: rtl/xcard_addr_decode.sv
module xcard_addr_decode
  import xcard_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [7:0]  WIN_PAGE = 8'h40,
  parameter logic [2:0]  LO_SEG   = 3'b010,
  parameter logic [2:0]  HI_SEG   = 3'b011,
  parameter int          RTC_W    = 4,
  parameter int          AUX_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              space_ok,
  input  logic              map_sw,
  input  logic              card_on,
  input  logic              map_bit,
  input  logic              upper_on,
  output sel_t              sel_d,
  output logic [RTC_W-1:0]  rtc_idx_d,
  output logic [AUX_W-1:0]  aux_idx_d
);
  localparam int PAGE_W = 8;
  localparam int SEG_W  = 3;

  logic               win;
  logic               lo_hit;
  logic               hi_hit;
  logic [1:0]         sub;
  logic [NUM_IDE-1:0] grp_hit;
  logic [NUM_IDE-1:0] rd_v;
  logic [NUM_IDE-1:0] wr_v;

  assign sub = addr[6:5];

  assign win    = space_ok && card_on && (map_bit == map_sw) &&
                  (addr[ADDR_W-1 -: PAGE_W] == WIN_PAGE);
  assign lo_hit = card_on && !win && (addr[ADDR_W-1 -: SEG_W] == LO_SEG);
  assign hi_hit = upper_on && (addr[ADDR_W-1 -: SEG_W] == HI_SEG);

  // One read/write pair per disk register group
  for (genvar g = 0; g < NUM_IDE; g++) begin : g_ide
    localparam logic [1:0] CODE = 2'(int'(SUB_IDE1) + g);
    assign grp_hit[g] = win && (sub == CODE);
    assign rd_v[g]    = grp_hit[g] && !addr[4];
    assign wr_v[g]    = grp_hit[g] &&  addr[4];
  end

  always_comb begin
    sel_d        = '0;
    sel_d.win    = win;
    sel_d.sram   = space_ok && (lo_hit || hi_hit);
    sel_d.aux    = win && (sub == SUB_AUX);
    sel_d.rtc    = win && (sub == SUB_RTC);
    sel_d.ide_rd = rd_v;
    sel_d.ide_wr = wr_v;
  end

  assign rtc_idx_d = addr[RTC_W:1];
  assign aux_idx_d = {addr[7], addr[AUX_W-2:0]};

endmodule

// File: rtl/xcard_decoder.sv
module xcard_decoder
  import xcard_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          LATCH_W   = 8,
  parameter logic [7:0]  CARD_BASE = 8'h11,
  parameter logic [7:0]  WIN_PAGE  = 8'h40,
  parameter int          RTC_W     = 4,
  parameter int          AUX_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic              ctl_bit,
  input  logic              map_sw,
  input  logic              space_ok,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              sel_win,
  output logic              sel_sram,
  output logic              sel_aux,
  output logic              sel_rtc,
  output logic              sel_ide1_rd,
  output logic              sel_ide1_wr,
  output logic              sel_ide2_rd,
  output logic              sel_ide2_wr,
  output logic [RTC_W-1:0]  rtc_index,
  output logic [AUX_W-1:0]  aux_index,
  output logic              card_en,
  output logic [1:0]        page_ctl,
  output logic              sram_wprot,
  output logic              irq_en,
  output logic              drive_rst
);
  logic [LATCH_W-1:0] latch_q;
  sel_t               sel_d;
  sel_t               sel_q;
  logic [RTC_W-1:0]   rtc_idx_d;
  logic [AUX_W-1:0]   aux_idx_d;

  xcard_ctl_latch #(
    .ADDR_W(ADDR_W), .LATCH_W(LATCH_W), .CARD_BASE(CARD_BASE)
  ) latch_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
    .ctl_bit(ctl_bit), .latch_q(latch_q)
  );

  xcard_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_PAGE(WIN_PAGE), .RTC_W(RTC_W), .AUX_W(AUX_W)
  ) dec_i (
    .addr(bus_addr), .space_ok(space_ok), .map_sw(map_sw),
    .card_on(latch_q[LB_ENABLE]), .map_bit(latch_q[LB_MAPSEL]),
    .upper_on(latch_q[LB_UPPER]),
    .sel_d(sel_d), .rtc_idx_d(rtc_idx_d), .aux_idx_d(aux_idx_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      rtc_index <= '0;
      aux_index <= '0;
    end else begin
      sel_q     <= sel_d;
      rtc_index <= rtc_idx_d;
      aux_index <= aux_idx_d;
    end
  end

  assign sel_win     = sel_q.win;
  assign sel_sram    = sel_q.sram;
  assign sel_aux     = sel_q.aux;
  assign sel_rtc     = sel_q.rtc;
  assign sel_ide1_rd = sel_q.ide_rd[0];
  assign sel_ide2_rd = sel_q.ide_rd[1];
  assign sel_ide1_wr = sel_q.ide_wr[0];
  assign sel_ide2_wr = sel_q.ide_wr[1];

  assign card_en    = latch_q[LB_ENABLE];
  assign page_ctl   = {latch_q[LB_PAGE1], latch_q[LB_PAGE0]};
  assign sram_wprot = latch_q[LB_WPROT];
  assign irq_en     = latch_q[LB_IRQ];
  assign drive_rst  = latch_q[LB_DRVRST];

  // R11: device selects never overlap, window never overlaps SRAM
  assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_sram, sel_aux, sel_rtc, sel_ide1_rd, sel_ide1_wr,
              sel_ide2_rd, sel_ide2_wr}) && !(sel_win && sel_sram));

  // R11: no select follows a cycle outside card space
  assert_qualifier_R11: assert property (@(posedge clk) disable iff (rst)
    !space_ok |=> !(sel_win || sel_sram || sel_aux || sel_rtc ||
                    sel_ide1_rd || sel_ide1_wr || sel_ide2_rd || sel_ide2_wr));

  // R6: upper SRAM window opens on bit 4 alone
  assert_upper_sram_R6: assert property (@(posedge clk) disable iff (rst)
    (space_ok && bus_addr[ADDR_W-1 -: 3] == 3'b011 && latch_q[LB_UPPER])
      |=> sel_sram);

  // R4: a device select only follows a register-window address
  assert_win_cover_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_aux || sel_rtc || sel_ide1_rd || sel_ide1_wr || sel_ide2_rd || sel_ide2_wr)
      |-> sel_win);

  // R9: clock index tracks the address one cycle later
  assert_rtc_index_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rtc_index == $past(bus_addr[RTC_W:1])));

  // R8: a write-port select follows an address with bit 4 set
  assert_ide_write_half_R8: assert property (@(posedge clk) disable iff (rst)
    (sel_ide1_wr || sel_ide2_wr) |-> $past(bus_addr[4]));

endmodule

// File: tb/xcard_decoder_tb.sv
module xcard_decoder_tb_top;
  localparam int BASE = 'h11;

  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_we;
  logic [15:0] ctl_addr;
  logic        ctl_bit;
  logic        map_sw;
  logic        space_ok;
  logic [15:0] bus_addr;
  logic        sel_win, sel_sram, sel_aux, sel_rtc;
  logic        sel_ide1_rd, sel_ide1_wr, sel_ide2_rd, sel_ide2_wr;
  logic [3:0]  rtc_index;
  logic [5:0]  aux_index;
  logic        card_en, sram_wprot, irq_en, drive_rst;
  logic [1:0]  page_ctl;

  xcard_decoder dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_bit(ctl_bit),
    .map_sw(map_sw), .space_ok(space_ok), .bus_addr(bus_addr),
    .sel_win(sel_win), .sel_sram(sel_sram), .sel_aux(sel_aux), .sel_rtc(sel_rtc),
    .sel_ide1_rd(sel_ide1_rd), .sel_ide1_wr(sel_ide1_wr),
    .sel_ide2_rd(sel_ide2_rd), .sel_ide2_wr(sel_ide2_wr),
    .rtc_index(rtc_index), .aux_index(aux_index), .card_en(card_en),
    .page_ctl(page_ctl), .sram_wprot(sram_wprot), .irq_en(irq_en),
    .drive_rst(drive_rst)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Reference model state
  logic [7:0] m_lat;
  bit e_win, e_sram, e_aux, e_rtc, e_i1r, e_i1w, e_i2r, e_i2w;
  int e_ridx, e_aidx;
  bit was_rst;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_lat = '0;
      {e_win, e_sram, e_aux, e_rtc, e_i1r, e_i1w, e_i2r, e_i2w} = '0;
      e_ridx = 0; e_aidx = 0; was_rst = 1'b1;
    end else begin
      int a, sub, low;
      bit en;
      a   = int'(bus_addr);
      en  = m_lat[0];
      sub = (a % 128) / 32;
      low = a % 32;
      e_win  = space_ok && (a / 256 == 'h40) && en && (m_lat[1] == map_sw);
      e_sram = space_ok && (((a >= 'h4000) && (a < 'h6000) && en && !e_win) ||
                            ((a >= 'h6000) && (a < 'h8000) && m_lat[4]));
      e_aux  = e_win && sub == 0;
      e_rtc  = e_win && sub == 1;
      e_i1r  = e_win && sub == 2 && low < 16;
      e_i1w  = e_win && sub == 2 && low >= 16;
      e_i2r  = e_win && sub == 3 && low < 16;
      e_i2w  = e_win && sub == 3 && low >= 16;
      e_ridx = low / 2;
      e_aidx = low + ((a / 128) % 2) * 32;
      was_rst = 1'b0;
      if (ctl_we && (int'(ctl_addr) / 256 == BASE))
        m_lat[(int'(ctl_addr) / 2) % 8] = ctl_bit;
    end
  end

  // Compare one nanosecond after each rising edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      string rt;
      rt = was_rst ? "R1" : "R12";
      chk(was_rst ? "R1" : "R4", "sel_win", sel_win, e_win);
      chk(was_rst ? "R1" : "R5 R6", "sel_sram", sel_sram, e_sram);
      chk(was_rst ? "R1" : "R7", "sel_aux", sel_aux, e_aux);
      chk(was_rst ? "R1" : "R7", "sel_rtc", sel_rtc, e_rtc);
      chk(was_rst ? "R1" : "R8", "ide_sel",
          {sel_ide1_rd, sel_ide1_wr, sel_ide2_rd, sel_ide2_wr},
          {e_i1r, e_i1w, e_i2r, e_i2w});
      chk(was_rst ? "R1" : "R9", "rtc_index", rtc_index, e_ridx);
      chk(was_rst ? "R1" : "R10", "aux_index", aux_index, e_aidx);
      chk(was_rst ? "R1" : "R2 R3", "latch_outs",
          {drive_rst, irq_en, sram_wprot, page_ctl, card_en},
          {m_lat[7], m_lat[6], m_lat[5], m_lat[3], m_lat[2], m_lat[0]});
      chk("R11", "overlap",
          int'(($countones({sel_sram, sel_aux, sel_rtc, sel_ide1_rd, sel_ide1_wr,
                            sel_ide2_rd, sel_ide2_wr}) <= 1) && !(sel_win && sel_sram)),
          1);
      chk(rt, "latency_tag", 0, 0);
    end
  end

  task automatic bus(input int a, input bit sp);
    @(negedge clk);
    bus_addr = a[15:0];
    space_ok = sp;
  endtask

  task automatic ctl(input int base, input int bitn, input bit v, input bit junk);
    @(negedge clk);
    ctl_we   = 1'b1;
    ctl_addr = {base[7:0], junk ? 4'hA : 4'h0, bitn[2:0], junk};
    ctl_bit  = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic sweep(input int lo, input int hi, input int step);
    for (int a = lo; a <= hi; a += step) bus(a, 1'b1);
  endtask

  task automatic edges();
    for (int k = 0; k < 10; k++) begin
      int pts[10] = '{'h3FFF, 'h4000, 'h401F, 'h4080, 'h40FF, 'h4100, 'h5FFF,
                      'h6000, 'h7FFF, 'h8000};
      bus(pts[k], 1'b1);
    end
  endtask

  initial begin
    rst = 1'b1; ctl_we = 1'b0; ctl_addr = '0; ctl_bit = 1'b0;
    map_sw = 1'b0; space_ok = 1'b0; bus_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: disabled card decodes nothing
    edges();
    // R2: foreign base must not enable
    ctl(BASE + 1, 0, 1'b1, 1'b0);
    edges();
    // R2: junk in unused control address bits, enable card
    ctl(BASE, 0, 1'b1, 1'b1);
    // R4 R7 R8 R9 R10: window open (bit1 == switch == 0)
    sweep('h4000, 'h40FF, 1);
    edges();
    // R11: qualifier low
    for (int a = 'h4000; a < 'h4100; a += 7) bus(a, 1'b0);
    // R5: window off, lower SRAM visible
    ctl(BASE, 1, 1'b1, 1'b0);
    edges();
    // R6: upper window, then with card disabled
    ctl(BASE, 4, 1'b1, 1'b0);
    edges();
    ctl(BASE, 0, 1'b0, 1'b0);
    edges();
    // switch flipped while disabled, then re-enable: bit1 == switch == 1
    @(negedge clk) map_sw = 1'b1;
    ctl(BASE, 0, 1'b1, 1'b0);
    sweep('h4000, 'h40FF, 3);
    // R3: side bits
    for (int b = 2; b < 8; b++) ctl(BASE, b, 1'b1, 1'b0);
    edges();
    for (int b = 2; b < 8; b++) ctl(BASE, b, 1'b0, 1'b0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 16) == 0) begin
        int bn;
        bn = $urandom % 8;
        if (bn == 0 && ($urandom % 2) == 0) @(negedge clk) map_sw = m_lat[0] ? map_sw : ~map_sw;
        ctl((($urandom % 4) == 0) ? BASE + 2 : BASE, bn, 1'($urandom), 1'($urandom));
      end else begin
        bus('h3F00 + ($urandom % 'h4200), (($urandom % 8) != 0));
      end
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule